// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This block sits on the load return path of a small RISC core, between the aligned 32-bit data-memory read word and the register-file write port. Each cycle it may receive one load request: the memory word, the two low address bits, a load-kind code and the current value of the destination register. From these it builds the 32-bit value to write back.

It supports signed and unsigned bytes, signed and unsigned halfwords, and whole words. It also supports a pair of partial-word merge loads, one filling the high end of the register and one filling the low end, so that two instructions in sequence can assemble a word from an unaligned address. The byte order is sampled from a configuration pin while reset is held and stays fixed until the next reset. A halfword or word request at an unaligned offset is flagged on an address-error output, and no write-back is issued for it. By default one register stage sits at the output. A parameter removes it and makes the block fully combinational.

Top module: `load_align_unit`

## Requirements
- R1: Kind code 0 is a signed byte load. The selected byte fills bits 7:0 and its bit 7 is copied into bits 31:8, so memory byte 0xFE gives 0xFFFF_FFFE.
- R2: Kind code 1 is an unsigned byte load. Bits 31:8 are zero, so 0xFE gives 0x0000_00FE.
- R3: Kind codes 2 (signed) and 3 (unsigned) load a halfword. In big-endian mode, offset 0 takes bits 31:16 and offset 2 takes bits 15:0. The extension follows the rule of R1 or R2, using bit 15.
- R4: Kind code 4 at offset 0 writes back the memory word unchanged.
- R5: Kind code 5 (merge-left) in big-endian mode at offset k places memory bytes k..3 in the top 4−k register bytes. The remaining low bytes keep the old register value. In this unit, byte 0 of the memory word is bits 31:24.
- R6: Kind code 6 (merge-right) in big-endian mode at offset k places memory bytes 0..k in the low k+1 register bytes. The remaining high bytes keep the old register value.
- R7: In little-endian mode, byte offset k selects bits 8k+7:8k. Halfword offset 0 selects bits 15:0 and offset 2 selects bits 31:16.
- R8: In little-endian mode at offset k, merge-left places memory bits 8k+7:0 in the top k+1 register bytes. Merge-right places memory bits 31:8k in the low 4−k register bytes. All other bytes keep the old register value.
- R9: A halfword request at an odd offset, or a word request at a nonzero offset, sets the address-error output and clears the write-back valid output. Merge and byte requests never raise the error.
- R10: The byte-order pin (1 = big-endian) is sampled only while reset is high. Changing it after reset does not change any result.
- R11: When the request valid input is low, or the kind code is 7 (reserved), both the write-back valid output and the address-error output are 0.
- R12: With the default registered output, a result appears one clock after its request. Reset clears the write-back valid and address-error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; byte order is sampled while it is high |
| big_endian_cfg | input | 1 | Byte-order select, 1 = big-endian, used only during reset |
| req_valid | input | 1 | A load result is being returned this cycle |
| req_kind | input | 3 | Load kind code (0..6, 7 reserved) |
| req_ofs | input | 2 | Low two bits of the load address |
| mem_word | input | 32 | Aligned word read from data memory |
| old_rd | input | 32 | Current destination register value, used by merge loads |
| wb_valid | output | 1 | Write the result to the register file |
| wb_data | output | 32 | Value to write back |
| addr_err | output | 1 | Misaligned halfword or word request |

## Verification
Some properties are checked on every cycle: an error always blocks the write-back, a misaligned word or halfword always raises the error, merge loads never raise it, an idle or reserved request produces no output activity, and unsigned loads always leave their upper bits zero. Other behaviour is shown only by the bench's vectors: which memory lane each offset selects in each byte order, how the old register bytes are kept during a merge, and that the byte-order pin is ignored outside reset.

// File: rtl/load_align_pkg.sv
package load_align_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        LK_BYTE_S  = 3'd0,
        LK_BYTE_U  = 3'd1,
        LK_HALF_S  = 3'd2,
        LK_HALF_U  = 3'd3,
        LK_WORD    = 3'd4,
        LK_MERGE_L = 3'd5,
        LK_MERGE_R = 3'd6,
        LK_RSVD    = 3'd7
    } ld_kind_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [WORD_W-1:0] data;
    } wb_pkt_t;

    function automatic logic kind_is_half(ld_kind_e k);
        return (k == LK_HALF_S) || (k == LK_HALF_U);
    endfunction

    function automatic logic kind_is_merge(ld_kind_e k);
        return (k == LK_MERGE_L) || (k == LK_MERGE_R);
    endfunction

    function automatic logic [WORD_W-1:0] extend_byte(logic [BYTE_W-1:0] b, logic signed_ld);
        return {{(WORD_W-BYTE_W){signed_ld & b[BYTE_W-1]}}, b};
    endfunction

    function automatic logic [WORD_W-1:0] extend_half(logic [HALF_W-1:0] h, logic signed_ld);
        return {{(WORD_W-HALF_W){signed_ld & h[HALF_W-1]}}, h};
    endfunction

endpackage

// File: rtl/lane_offset_map.sv
module lane_offset_map
    import load_align_pkg::*;
(
    input  logic             big_endian,
    input  ld_kind_e         kind,
    input  logic [OFS_W-1:0] ofs,
    output logic [OFS_W-1:0] lane,
    output logic             misaligned,
    output logic             reserved
);
    localparam logic [OFS_W-1:0] TOP_LANE  = OFS_W'(LANES - 1);
    localparam logic [OFS_W-1:0] HALF_LANE = OFS_W'(LANES - 2);

    // Every request is turned into a big-endian lane number, so the merge
    // logic needs only one form.
    always_comb begin
        if (big_endian)
            lane = ofs;
        else if (kind_is_half(kind))
            lane = HALF_LANE - ofs;
        else
            lane = TOP_LANE - ofs;
    end

    always_comb begin
        unique case (kind)
            LK_HALF_S, LK_HALF_U: misaligned = ofs[0];
            LK_WORD:              misaligned = (ofs != '0);
            default:              misaligned = 1'b0;
        endcase
    end

    assign reserved = (kind == LK_RSVD);

endmodule

// File: rtl/byte_merge.sv
module byte_merge
    import load_align_pkg::*;
(
    input  ld_kind_e          kind,
    input  logic [OFS_W-1:0]  lane,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] old_rd,
    output logic [WORD_W-1:0] result
);
    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic [WORD_W-1:0] merged_l;
    logic [WORD_W-1:0] merged_r;

    always_comb begin
        sel_byte = mem_word[WORD_W-1-BYTE_W*int'(lane) -: BYTE_W];
        sel_half = mem_word[WORD_W-1-HALF_W*int'(lane[OFS_W-1:1]) -: HALF_W];
    end

    // Register byte j is counted from the most significant end.
    always_comb begin
        merged_l = old_rd;
        merged_r = old_rd;
        for (int j = 0; j < LANES; j++) begin
            if (j < LANES - int'(lane))
                merged_l[WORD_W-1-BYTE_W*j -: BYTE_W] =
                    mem_word[WORD_W-1-BYTE_W*(j+int'(lane)) -: BYTE_W];
            if (j >= LANES - 1 - int'(lane))
                merged_r[WORD_W-1-BYTE_W*j -: BYTE_W] =
                    mem_word[WORD_W-1-BYTE_W*(j-(LANES-1-int'(lane))) -: BYTE_W];
        end
    end

    always_comb begin
        unique case (kind)
            LK_BYTE_S:  result = extend_byte(sel_byte, 1'b1);
            LK_BYTE_U:  result = extend_byte(sel_byte, 1'b0);
            LK_HALF_S:  result = extend_half(sel_half, 1'b1);
            LK_HALF_U:  result = extend_half(sel_half, 1'b0);
            LK_MERGE_L: result = merged_l;
            LK_MERGE_R: result = merged_r;
            default:    result = mem_word;
        endcase
    end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
    import load_align_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        big_endian_cfg,
    input  logic        req_valid,
    input  logic [2:0]  req_kind,
    input  logic [1:0]  req_ofs,
    input  logic [31:0] mem_word,
    input  logic [31:0] old_rd,
    output logic        wb_valid,
    output logic [31:0] wb_data,
    output logic        addr_err
);
    logic             be_q;
    ld_kind_e         kind;
    logic [OFS_W-1:0] lane;
    logic             misaligned;
    logic             reserved;
    logic [WORD_W-1:0] result;
    wb_pkt_t          pkt_d;
    wb_pkt_t          pkt_q;

    assign kind = ld_kind_e'(req_kind);

    always_ff @(posedge clk) begin
        if (rst)
            be_q <= big_endian_cfg;
    end

    lane_offset_map u_map (
        .big_endian (be_q),
        .kind       (kind),
        .ofs        (req_ofs),
        .lane       (lane),
        .misaligned (misaligned),
        .reserved   (reserved)
    );

    byte_merge u_merge (
        .kind     (kind),
        .lane     (lane),
        .mem_word (mem_word),
        .old_rd   (old_rd),
        .result   (result)
    );

    always_comb begin
        pkt_d.valid = req_valid & ~misaligned & ~reserved;
        pkt_d.err   = req_valid & misaligned;
        pkt_d.data  = result;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    pkt_q <= '0;
                else
                    pkt_q <= pkt_d;
            end
        end else begin : g_bypass
            assign pkt_q = pkt_d;
        end
    endgenerate

    assign wb_valid = pkt_q.valid;
    assign addr_err = pkt_q.err;
    assign wb_data  = pkt_q.data;

endmodule

// File: rtl/load_align_chk.sv
module load_align_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_kind,
    input logic [1:0]  req_ofs,
    input logic        wb_valid,
    input logic [31:0] wb_data,
    input logic        addr_err
);
    // Request as seen at the output's time step.
    logic       d_valid;
    logic [2:0] d_kind;
    logic [1:0] d_ofs;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_valid <= 1'b0;
                    d_kind  <= 3'd0;
                    d_ofs   <= 2'd0;
                end else begin
                    d_valid <= req_valid;
                    d_kind  <= req_kind;
                    d_ofs   <= req_ofs;
                end
            end
        end else begin : g_now
            assign d_valid = req_valid;
            assign d_kind  = req_kind;
            assign d_ofs   = req_ofs;
        end
    endgenerate

    p_err_blocks_wb_r9: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> !wb_valid);

    p_word_misalign_r9: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_kind == 3'd4 && d_ofs != 2'd0) |-> addr_err);

    p_half_misalign_r3: assert property (@(posedge clk) disable iff (rst)
        (d_valid && (d_kind == 3'd2 || d_kind == 3'd3) && d_ofs[0]) |-> addr_err);

    p_merge_no_err_r5: assert property (@(posedge clk) disable iff (rst)
        (d_valid && (d_kind == 3'd5 || d_kind == 3'd6)) |-> (wb_valid && !addr_err));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!d_valid || d_kind == 3'd7) |-> (!wb_valid && !addr_err));

    p_byte_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_kind == 3'd1) |-> (wb_valid && wb_data[31:8] == 24'h0));

    p_half_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_kind == 3'd3 && !d_ofs[0]) |-> (wb_data[31:16] == 16'h0));

    p_word_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_kind == 3'd4 && d_ofs == 2'd0) |-> (wb_valid && !addr_err));

endmodule

bind load_align_unit load_align_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_ofs   (req_ofs),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .addr_err  (addr_err)
);

// File: tb/test_load_align_unit.sv
module test_load_align_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_endian_cfg = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [1:0]  req_ofs = 2'd0;
    logic [31:0] mem_word = 32'h0;
    logic [31:0] old_rd = 32'h0;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic        addr_err;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [31:0] MEM = 32'h80FE_7F01;
    localparam logic [31:0] OLD = 32'hA1B2_C3D4;

    always #10 clk = ~clk;

    load_align_unit i_load_align_unit (
        .clk            (clk),
        .rst            (rst),
        .big_endian_cfg (big_endian_cfg),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_ofs        (req_ofs),
        .mem_word       (mem_word),
        .old_rd         (old_rd),
        .wb_valid       (wb_valid),
        .wb_data        (wb_data),
        .addr_err       (addr_err)
    );

    typedef struct packed {
        logic        be;
        logic [2:0]  kind;
        logic [1:0]  ofs;
        logic        err;
        logic [3:0]  req;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 2'd0, 1'b0, 4'd1,  32'hFFFF_FF80}, // R1
        '{1'b1, 3'd1, 2'd1, 1'b0, 4'd2,  32'h0000_00FE}, // R2
        '{1'b1, 3'd0, 2'd1, 1'b0, 4'd1,  32'hFFFF_FFFE}, // R1
        '{1'b1, 3'd0, 2'd2, 1'b0, 4'd1,  32'h0000_007F}, // R1
        '{1'b1, 3'd1, 2'd3, 1'b0, 4'd2,  32'h0000_0001}, // R2
        '{1'b1, 3'd2, 2'd0, 1'b0, 4'd3,  32'hFFFF_80FE}, // R3
        '{1'b1, 3'd3, 2'd2, 1'b0, 4'd3,  32'h0000_7F01}, // R3
        '{1'b1, 3'd4, 2'd0, 1'b0, 4'd4,  32'h80FE_7F01}, // R4
        '{1'b1, 3'd5, 2'd1, 1'b0, 4'd5,  32'hFE7F_01D4}, // R5
        '{1'b1, 3'd5, 2'd3, 1'b0, 4'd5,  32'h01B2_C3D4}, // R5
        '{1'b1, 3'd5, 2'd0, 1'b0, 4'd5,  32'h80FE_7F01}, // R5
        '{1'b1, 3'd6, 2'd0, 1'b0, 4'd6,  32'hA1B2_C380}, // R6
        '{1'b1, 3'd6, 2'd2, 1'b0, 4'd6,  32'hA180_FE7F}, // R6
        '{1'b1, 3'd6, 2'd3, 1'b0, 4'd6,  32'h80FE_7F01}, // R6
        '{1'b1, 3'd2, 2'd1, 1'b1, 4'd9,  32'h0},         // R9
        '{1'b1, 3'd4, 2'd2, 1'b1, 4'd9,  32'h0},         // R9
        '{1'b0, 3'd0, 2'd0, 1'b0, 4'd7,  32'h0000_0001}, // R7
        '{1'b0, 3'd0, 2'd3, 1'b0, 4'd7,  32'hFFFF_FF80}, // R7
        '{1'b0, 3'd1, 2'd2, 1'b0, 4'd7,  32'h0000_00FE}, // R7
        '{1'b0, 3'd2, 2'd0, 1'b0, 4'd7,  32'h0000_7F01}, // R7
        '{1'b0, 3'd2, 2'd2, 1'b0, 4'd7,  32'hFFFF_80FE}, // R7
        '{1'b0, 3'd5, 2'd0, 1'b0, 4'd8,  32'h01B2_C3D4}, // R8
        '{1'b0, 3'd5, 2'd2, 1'b0, 4'd8,  32'hFE7F_01D4}, // R8
        '{1'b0, 3'd6, 2'd0, 1'b0, 4'd8,  32'h80FE_7F01}, // R8
        '{1'b0, 3'd6, 2'd1, 1'b0, 4'd8,  32'hA180_FE7F}, // R8
        '{1'b0, 3'd3, 2'd3, 1'b1, 4'd9,  32'h0}          // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic be);
        @(negedge clk);
        rst = 1'b1;
        big_endian_cfg = be;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        big_endian_cfg = ~be;
    endtask

    // Drive at a falling edge; the registered result is sampled one edge later.
    task automatic issue(input logic v, input logic [2:0] k, input logic [1:0] o);
        @(negedge clk);
        req_valid = v;
        req_kind  = k;
        req_ofs   = o;
        mem_word  = MEM;
        old_rd    = OLD;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic cur_be;
        // R12: reset clears the outputs
        do_reset(1'b1);
        cur_be = 1'b1;
        check("R12 reset wb_valid", {31'h0, wb_valid}, 32'h0);
        check("R12 reset addr_err", {31'h0, addr_err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].be != cur_be) begin
                do_reset(VECS[i].be);
                cur_be = VECS[i].be;
            end
            issue(1'b1, VECS[i].kind, VECS[i].ofs);
            check($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'h0, addr_err}, {31'h0, VECS[i].err});
            check($sformatf("R%0d vec %0d valid", VECS[i].req, i), {31'h0, wb_valid}, {31'h0, ~VECS[i].err});
            if (!VECS[i].err)
                check($sformatf("R%0d vec %0d data", VECS[i].req, i), wb_data, VECS[i].exp);
        end

        // R10: pin held at the opposite value after a big-endian reset
        do_reset(1'b1);
        big_endian_cfg = 1'b0;
        issue(1'b1, 3'd0, 2'd0);
        check("R10 byte order unchanged", wb_data, 32'hFFFF_FF80);

        // R11: idle request and reserved code
        issue(1'b0, 3'd4, 2'd1);
        check("R11 idle valid", {31'h0, wb_valid}, 32'h0);
        check("R11 idle err", {31'h0, addr_err}, 32'h0);
        issue(1'b1, 3'd7, 2'd1);
        check("R11 reserved valid", {31'h0, wb_valid}, 32'h0);
        check("R11 reserved err", {31'h0, addr_err}, 32'h0);

        // R12: one-cycle latency, output gone after the request drops
        issue(1'b1, 3'd4, 2'd0);
        check("R12 latency valid", {31'h0, wb_valid}, 32'h1);
        @(negedge clk);
        check("R12 valid drops", {31'h0, wb_valid}, 32'h0);

        // R9: word at offset 1 in big-endian mode
        issue(1'b1, 3'd4, 2'd1);
        check("R9 word ofs1 err", {31'h0, addr_err}, 32'h1);

        finish_run();
    end

endmodule